// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a legacy peripheral-controller device as seen from an 8-bit I/O bus. Two adjacent I/O addresses make up the port. The lower address takes key bytes and index values. The upper address reads and writes the register selected by the current index. Configuration access stays closed until software writes the unlock byte to the index address twice with no other index write in between. A separate lock byte closes access again.

Once the port is open, a few global indices hold the logical-device selector and a fixed chip identifier. Indices from 0x30 upward reach a small register bank that belongs to the logical device currently selected, and each device has its own bank. Bit 0 of a device's first bank register is its activate bit, and it drives a per-device enable output. Every data-port write to an index at 0x30 or above is also passed on to the logical devices as a one-cycle write strobe, together with the index, the device number and the data.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, the index, device selector and all bank registers are 0x00, `ldActive` is all zero and `ldWrStb` is low.
- R2: The port opens at the clock edge that takes the second of two consecutive index-address writes of 0x87. Any other index-address write between them cancels the partial match. Reads and data-address accesses do not cancel it.
- R3: While the port is open, an index-address write of 0xAA locks it and leaves the index unchanged. Any other open index-address write loads the index.
- R4: While the port is locked, reads of either port address return 0xFF, and data-address writes change no register and raise no strobe.
- R5: While the port is open, a read of the index address returns the current index.
- R6: Index 0x07 is the logical-device selector: a full 8-bit read/write register that keeps its value across lock and unlock.
- R7: Index 0x20 reads the parameter `CHIP_ID`, and writes to it have no effect.
- R8: Indices 0x30 to 0x30+BANK_REGS-1 are read/write bytes held separately for every device number below `NUM_LD`. A write takes effect at the next clock edge.
- R9: `ldActive[n]` equals bit 0 of index 0x30 in the bank of device n.
- R10: An open data-address write with index 0x30 or above raises `ldWrStb` for exactly the following cycle. In that cycle `ldWrIdx`, `ldWrLd` and `ldWrData` carry the index, the selected device number and the written byte. This holds even when no bank register exists at that index or device.
- R11: Only `BASE_ADDR` (index) and `BASE_ADDR+1` (data) respond. Other addresses change no state, and a read of any other address returns 0xFF.
- R12: While the port is open, data reads of indices with no register return 0x00. This covers bank indices past the bank size and any bank index while the selected device number is `NUM_LD` or higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | ADDR_W | I/O address of the current access |
| ioWr | input | 1 | Write strobe, one access per cycle |
| ioRd | input | 1 | Read strobe |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data, combinational from address and state |
| ldActive | output | NUM_LD | Activate bit of each logical device |
| ldWrStb | output | 1 | One-cycle register-write strobe toward the logical devices |
| ldWrIdx | output | 8 | Index of the forwarded write |
| ldWrLd | output | 8 | Device number of the forwarded write |
| ldWrData | output | 8 | Data of the forwarded write |

## Verification
The bench builds the port with base 0x4E, ten logical devices and four bank registers per device. A 0x2E read and a write to 0x50 therefore exercise the address decode against the wrong base. Index 0x34 lies past the bank, so reads there must return zero while writes there are still forwarded. Device numbers 8 and 9 are the top of the bank range, and selecting device 12 reaches the out-of-range case. The small sizes let a short vector table cover unlock interruption, relocking, per-device bank separation and activate-bit fan-out.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam logic [7:0] KEY_UNLOCK = 8'h87;
  localparam logic [7:0] KEY_LOCK   = 8'hAA;
  localparam logic [7:0] IDX_LDSEL  = 8'h07;
  localparam logic [7:0] IDX_CHIPID = 8'h20;
  localparam logic [7:0] IDX_BANK0  = 8'h30;
  localparam logic [7:0] BUS_FLOAT  = 8'hFF;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } keyState_t;

  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic open;
    logic idxWr;
    logic dataWr;
    logic idxRd;
    logic dataRd;
  } cfgStb_t;

endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 'h2E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        ioWdata,
  output cfgStb_t           stb
);

  localparam logic [ADDR_W-1:0] IDX_ADDR  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(BASE_ADDR + 1);

  keyState_t keyState, keyNext;
  logic hitIdx, hitData, idxWrite, isUnlock, isLock;

  assign hitIdx   = (ioAddr == IDX_ADDR);
  assign hitData  = (ioAddr == DATA_ADDR);
  assign idxWrite = ioWr && hitIdx;
  assign isUnlock = (ioWdata == KEY_UNLOCK);
  assign isLock   = (ioWdata == KEY_LOCK);

  always_comb begin
    keyNext = keyState;
    unique case (keyState)
      KEY_IDLE: if (idxWrite) keyNext = isUnlock ? KEY_HALF : KEY_IDLE;
      KEY_HALF: if (idxWrite) keyNext = isUnlock ? KEY_OPEN : KEY_IDLE;
      KEY_OPEN: if (idxWrite && isLock) keyNext = KEY_IDLE;
      default:  keyNext = KEY_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyState <= KEY_IDLE;
    else       keyState <= keyNext;
  end

  always_comb begin
    stb.open   = (keyState == KEY_OPEN);
    stb.idxWr  = stb.open && idxWrite && !isLock;
    stb.dataWr = stb.open && ioWr && hitData;
    stb.idxRd  = ioRd && hitIdx;
    stb.dataRd = ioRd && hitData;
  end

endmodule

// File: rtl/sio_cfg_dpath.sv
module sio_cfg_dpath
  import sio_cfg_pkg::*;
#(
  parameter int unsigned NUM_LD    = 12,
  parameter int unsigned BANK_REGS = 8,
  parameter logic [7:0]  CHIP_ID   = 8'h5C
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStb_t           stb,
  input  logic [7:0]        ioWdata,
  output logic [7:0]        ioRdata,
  output logic [NUM_LD-1:0] ldActive,
  output logic              ldWrStb,
  output logic [7:0]        ldWrIdx,
  output logic [7:0]        ldWrLd,
  output logic [7:0]        ldWrData
);

  localparam int unsigned OFF_W    = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;
  localparam int unsigned BANK_END = 32'h30 + BANK_REGS;

  logic [7:0]       index, ldSel;
  logic [7:0]       bank [NUM_LD][BANK_REGS];
  logic [OFF_W-1:0] off;
  logic             inBankRange, ldValid, bankHit, fwdHit;
  logic [7:0]       bankVal, regVal;
  logic [7:0]       idxDelta;

  assign idxDelta    = index - IDX_BANK0;
  assign off         = idxDelta[OFF_W-1:0];
  assign fwdHit      = (index >= IDX_BANK0);
  assign inBankRange = fwdHit && ({1'b0, index} < 9'(BANK_END));
  assign ldValid     = ({24'd0, ldSel} < NUM_LD);
  assign bankHit     = inBankRange && ldValid;

  // Index and device selector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      index <= '0;
      ldSel <= '0;
    end else begin
      if (stb.idxWr) index <= ioWdata;
      if (stb.dataWr && index == IDX_LDSEL) ldSel <= ioWdata;
    end
  end

  // Banked per-device registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int ld = 0; ld < NUM_LD; ld++)
        for (int r = 0; r < BANK_REGS; r++)
          bank[ld][r] <= '0;
    end else if (stb.dataWr && bankHit) begin
      for (int ld = 0; ld < NUM_LD; ld++)
        for (int r = 0; r < BANK_REGS; r++)
          if (ldSel == 8'(ld) && off == OFF_W'(r)) bank[ld][r] <= ioWdata;
    end
  end

  for (genvar g = 0; g < NUM_LD; g++) begin : g_act
    assign ldActive[g] = bank[g][0][0];
  end

  always_comb begin
    bankVal = '0;
    for (int ld = 0; ld < NUM_LD; ld++)
      for (int r = 0; r < BANK_REGS; r++)
        if (ldSel == 8'(ld) && off == OFF_W'(r)) bankVal = bank[ld][r];
  end

  always_comb begin
    if (index == IDX_LDSEL)       regVal = ldSel;
    else if (index == IDX_CHIPID) regVal = CHIP_ID;
    else if (bankHit)             regVal = bankVal;
    else                          regVal = 8'h00;
  end

  always_comb begin
    if (stb.open && stb.idxRd)       ioRdata = index;
    else if (stb.open && stb.dataRd) ioRdata = regVal;
    else                             ioRdata = BUS_FLOAT;
  end

  // Forwarded write toward the logical devices
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldWrStb  <= 1'b0;
      ldWrIdx  <= '0;
      ldWrLd   <= '0;
      ldWrData <= '0;
    end else begin
      ldWrStb <= stb.dataWr && fwdHit;
      if (stb.dataWr && fwdHit) begin
        ldWrIdx  <= index;
        ldWrLd   <= ldSel;
        ldWrData <= ioWdata;
      end
    end
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 'h2E,
  parameter int unsigned NUM_LD    = 12,
  parameter int unsigned BANK_REGS = 8,
  parameter logic [7:0]  CHIP_ID   = 8'h5C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        ioWdata,
  output logic [7:0]        ioRdata,
  output logic [NUM_LD-1:0] ldActive,
  output logic              ldWrStb,
  output logic [7:0]        ldWrIdx,
  output logic [7:0]        ldWrLd,
  output logic [7:0]        ldWrData
);

  cfgStb_t stb;
  logic    cfgOpen;

  assign cfgOpen = stb.open;

  sio_cfg_ctrl #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ioAddr (ioAddr),
    .ioWr   (ioWr),
    .ioRd   (ioRd),
    .ioWdata(ioWdata),
    .stb    (stb)
  );

  sio_cfg_dpath #(
    .NUM_LD   (NUM_LD),
    .BANK_REGS(BANK_REGS),
    .CHIP_ID  (CHIP_ID)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .ioWdata (ioWdata),
    .ioRdata (ioRdata),
    .ldActive(ldActive),
    .ldWrStb (ldWrStb),
    .ldWrIdx (ldWrIdx),
    .ldWrLd  (ldWrLd),
    .ldWrData(ldWrData)
  );

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 'h2E,
  parameter int unsigned NUM_LD    = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWr,
  input logic              ioRd,
  input logic [7:0]        ioWdata,
  input logic [7:0]        ioRdata,
  input logic [NUM_LD-1:0] ldActive,
  input logic              ldWrStb,
  input logic              cfgOpen
);

  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(BASE_ADDR + 1);

  logic hit;
  assign hit = (ioAddr == IDX_A) || (ioAddr == DAT_A);

  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgOpen) |-> $past(ioWr && ioAddr == IDX_A && ioWdata == 8'h87));

  p_lock_key_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOpen && ioWr && ioAddr == IDX_A && ioWdata == 8'hAA) |=> !cfgOpen);

  p_locked_float_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgOpen && ioRd && hit) |-> ioRdata == 8'hFF);

  p_active_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ioWr) |-> $stable(ldActive));

  p_stb_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    ldWrStb |-> $past(cfgOpen && ioWr && ioAddr == DAT_A));

  p_miss_float_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !hit) |-> ioRdata == 8'hFF);

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR),
  .NUM_LD   (NUM_LD)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ioAddr  (ioAddr),
  .ioWr    (ioWr),
  .ioRd    (ioRd),
  .ioWdata (ioWdata),
  .ioRdata (ioRdata),
  .ldActive(ldActive),
  .ldWrStb (ldWrStb),
  .cfgOpen (cfgOpen)
);

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;

  localparam int unsigned NLD = 10;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [15:0]    ioAddr = '0;
  logic           ioWr = 1'b0;
  logic           ioRd = 1'b0;
  logic [7:0]     ioWdata = '0;
  logic [7:0]     ioRdata;
  logic [NLD-1:0] ldActive;
  logic           ldWrStb;
  logic [7:0]     ldWrIdx, ldWrLd, ldWrData;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sio_cfg_port #(
    .ADDR_W(16), .BASE_ADDR('h4E), .NUM_LD(NLD), .BANK_REGS(4), .CHIP_ID(8'h5C)
  ) u0 (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .ldActive(ldActive),
    .ldWrStb(ldWrStb), .ldWrIdx(ldWrIdx), .ldWrLd(ldWrLd), .ldWrData(ldWrData)
  );

  typedef struct packed {
    logic [15:0] a;
    logic        w;
    logic        r;
    logic [7:0]  d;
    logic [7:0]  e;
    logic        s;
    logic [3:0]  req;
  } vec_t;

  localparam logic [15:0] BI = 16'h004E;
  localparam logic [15:0] BD = 16'h004F;

  localparam vec_t VEC [53] = '{
    '{BD, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 4'd4},  // 0  R4 locked data read
    '{BI, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 4'd4},  // 1  R4 locked index read
    '{BD, 1'b1, 1'b0, 8'h55, 8'h00, 1'b0, 4'd4},  // 2  R4 locked write, no strobe
    '{BI, 1'b1, 1'b0, 8'h87, 8'h00, 1'b0, 4'd2},  // 3  R2
    '{BI, 1'b1, 1'b0, 8'h12, 8'h00, 1'b0, 4'd2},  // 4  R2 breaks match
    '{BI, 1'b1, 1'b0, 8'h87, 8'h00, 1'b0, 4'd2},  // 5  R2
    '{BD, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 4'd2},  // 6  R2 still locked
    '{BI, 1'b1, 1'b0, 8'h87, 8'h00, 1'b0, 4'd2},  // 7  R2 opens
    '{BI, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 4'd5},  // 8  R5 index still 0
    '{BI, 1'b1, 1'b0, 8'h20, 8'h00, 1'b0, 4'd3},  // 9  R3
    '{BD, 1'b0, 1'b1, 8'h00, 8'h5C, 1'b0, 4'd7},  // 10 R7
    '{BD, 1'b1, 1'b0, 8'h33, 8'h00, 1'b0, 4'd7},  // 11 R7
    '{BD, 1'b0, 1'b1, 8'h00, 8'h5C, 1'b0, 4'd7},  // 12 R7 unchanged
    '{BI, 1'b1, 1'b0, 8'h07, 8'h00, 1'b0, 4'd6},  // 13 R6
    '{BD, 1'b1, 1'b0, 8'h08, 8'h00, 1'b0, 4'd6},  // 14 R6
    '{BD, 1'b0, 1'b1, 8'h00, 8'h08, 1'b0, 4'd6},  // 15 R6
    '{BI, 1'b0, 1'b1, 8'h00, 8'h07, 1'b0, 4'd5},  // 16 R5
    '{BI, 1'b1, 1'b0, 8'h30, 8'h00, 1'b0, 4'd8},  // 17 R8
    '{BD, 1'b1, 1'b0, 8'h01, 8'h00, 1'b1, 4'd10}, // 18 R10
    '{BD, 1'b0, 1'b1, 8'h00, 8'h01, 1'b0, 4'd8},  // 19 R8
    '{BI, 1'b1, 1'b0, 8'h31, 8'h00, 1'b0, 4'd8},  // 20 R8
    '{BD, 1'b1, 1'b0, 8'hA5, 8'h00, 1'b1, 4'd10}, // 21 R10
    '{BD, 1'b0, 1'b1, 8'h00, 8'hA5, 1'b0, 4'd8},  // 22 R8
    '{BI, 1'b1, 1'b0, 8'h07, 8'h00, 1'b0, 4'd6},  // 23 R6
    '{BD, 1'b1, 1'b0, 8'h03, 8'h00, 1'b0, 4'd6},  // 24 R6
    '{BI, 1'b1, 1'b0, 8'h31, 8'h00, 1'b0, 4'd8},  // 25 R8
    '{BD, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 4'd8},  // 26 R8 device 3 separate
    '{BD, 1'b1, 1'b0, 8'h3C, 8'h00, 1'b1, 4'd10}, // 27 R10
    '{BD, 1'b0, 1'b1, 8'h00, 8'h3C, 1'b0, 4'd8},  // 28 R8
    '{BI, 1'b1, 1'b0, 8'h07, 8'h00, 1'b0, 4'd6},  // 29 R6
    '{BD, 1'b1, 1'b0, 8'h08, 8'h00, 1'b0, 4'd6},  // 30 R6
    '{BI, 1'b1, 1'b0, 8'h31, 8'h00, 1'b0, 4'd8},  // 31 R8
    '{BD, 1'b0, 1'b1, 8'h00, 8'hA5, 1'b0, 4'd8},  // 32 R8 device 8 kept
    '{BI, 1'b1, 1'b0, 8'h34, 8'h00, 1'b0, 4'd12}, // 33 R12
    '{BD, 1'b1, 1'b0, 8'h77, 8'h00, 1'b1, 4'd10}, // 34 R10 forwarded past bank
    '{BD, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 4'd12}, // 35 R12
    '{BI, 1'b1, 1'b0, 8'h07, 8'h00, 1'b0, 4'd6},  // 36 R6
    '{BD, 1'b1, 1'b0, 8'h0C, 8'h00, 1'b0, 4'd6},  // 37 R6
    '{BI, 1'b1, 1'b0, 8'h30, 8'h00, 1'b0, 4'd12}, // 38 R12
    '{BD, 1'b1, 1'b0, 8'h01, 8'h00, 1'b1, 4'd10}, // 39 R10 device 12 forwarded
    '{BD, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 4'd12}, // 40 R12
    '{16'h0050, 1'b1, 1'b0, 8'h11, 8'h00, 1'b0, 4'd11}, // 41 R11
    '{BI, 1'b0, 1'b1, 8'h00, 8'h30, 1'b0, 4'd11}, // 42 R11 index untouched
    '{16'h002E, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 4'd11}, // 43 R11
    '{BI, 1'b1, 1'b0, 8'h07, 8'h00, 1'b0, 4'd3},  // 44 R3
    '{BI, 1'b1, 1'b0, 8'hAA, 8'h00, 1'b0, 4'd3},  // 45 R3 lock
    '{BD, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 4'd3},  // 46 R3
    '{BD, 1'b1, 1'b0, 8'h09, 8'h00, 1'b0, 4'd4},  // 47 R4
    '{BI, 1'b1, 1'b0, 8'h87, 8'h00, 1'b0, 4'd2},  // 48 R2
    '{BI, 1'b1, 1'b0, 8'h87, 8'h00, 1'b0, 4'd2},  // 49 R2
    '{BI, 1'b0, 1'b1, 8'h00, 8'h07, 1'b0, 4'd3},  // 50 R3 index kept
    '{BD, 1'b0, 1'b1, 8'h00, 8'h0C, 1'b0, 4'd4},  // 51 R4 locked write ignored
    '{BI, 1'b1, 1'b0, 8'hAA, 8'h00, 1'b0, 4'd3}   // 52 R3
  };

  task automatic doOp(input logic [15:0] a, input logic w, input logic r,
                      input logic [7:0] d, output logic [7:0] rv);
    @(negedge clk);
    ioAddr = a; ioWr = w; ioRd = r; ioWdata = d;
    #1 rv = ioRdata;
    @(posedge clk);
    #1;
    ioWr = 1'b0; ioRd = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    logic [7:0] rv;
    repeat (3) @(posedge clk);
    #1;
    check(ldWrStb == 1'b0 && ldActive == '0, "R1 reset outputs",
          {ldWrStb, 21'd0, ldActive}, 32'd0);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < 53; i++) begin
      doOp(VEC[i].a, VEC[i].w, VEC[i].r, VEC[i].d, rv);
      nVec++;
      if ((VEC[i].r && rv !== VEC[i].e) || ldWrStb !== VEC[i].s) begin
        nBad++;
        $display("FAIL vector %0d R%0d actual rd=%0h stb=%0b expected rd=%0h stb=%0b",
                 i, VEC[i].req, rv, ldWrStb, VEC[i].e, VEC[i].s);
      end
    end

    // R9: only device 8 has its activate bit set
    check(ldActive == 10'h100, "R9 after table", 32'(ldActive), 32'h100);

    // R10: forwarded payload and single-cycle width
    doOp(BI, 1'b1, 1'b0, 8'h87, rv);
    doOp(BI, 1'b1, 1'b0, 8'h87, rv);
    doOp(BI, 1'b1, 1'b0, 8'h07, rv);
    doOp(BD, 1'b1, 1'b0, 8'h09, rv);
    doOp(BI, 1'b1, 1'b0, 8'h32, rv);
    doOp(BD, 1'b1, 1'b0, 8'hC3, rv);
    check(ldWrStb && ldWrIdx == 8'h32 && ldWrLd == 8'h09 && ldWrData == 8'hC3,
          "R10 payload", {7'd0, ldWrStb, ldWrIdx, ldWrLd, ldWrData},
          {7'd0, 1'b1, 24'h3209C3});
    doOp(BI, 1'b0, 1'b1, 8'h00, rv);
    check(ldWrStb == 1'b0, "R10 one cycle", 32'(ldWrStb), 32'd0);

    // R9: activate bit fan-out for device 9
    doOp(BI, 1'b1, 1'b0, 8'h30, rv);
    doOp(BD, 1'b1, 1'b0, 8'h03, rv);
    check(ldActive == 10'h300, "R9 set device 9", 32'(ldActive), 32'h300);
    doOp(BD, 1'b1, 1'b0, 8'h02, rv);
    check(ldActive == 10'h100, "R9 clear device 9", 32'(ldActive), 32'h100);

    // R1: reset mid-run
    @(negedge clk) rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(ldActive == '0 && ldWrStb == 1'b0, "R1 reset again",
          {ldWrStb, 21'd0, ldActive}, 32'd0);
    doOp(BD, 1'b0, 1'b1, 8'h00, rv);
    check(rv == 8'hFF, "R1 locked after reset", 32'(rv), 32'hFF);
    doOp(BI, 1'b1, 1'b0, 8'h87, rv);
    doOp(BI, 1'b1, 1'b0, 8'h87, rv);
    doOp(BI, 1'b1, 1'b0, 8'h07, rv);
    doOp(BD, 1'b0, 1'b1, 8'h00, rv);
    check(rv == 8'h00, "R1 selector cleared", 32'(rv), 32'h00);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      nVec++;
      nBad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule